// File: doc/BRIEF.md
# Single-Frame Register-Mapped Network Interface

This block is a minimal network interface for a processor that has no DMA. It holds exactly one received frame and one frame being assembled for transmission. The processor reaches everything through a small register window. It reads received bytes one at a time from a data port, and it pushes outgoing bytes one at a time into another data port after announcing the length.

Frames arrive on a byte stream with valid, data and last signals. A frame is taken only when the interface is idle and the receive buffer is empty enough. A completed transmit frame leaves on a byte stream with valid, data and last, paced by a ready input.

A three-bit interrupt-control register drives one level interrupt. Its bits are transmit done, receive done and self-test. A busy flag is derived from these bits and stops reception while the processor still owes an acknowledgement. Writing the self-test bit clears the whole block and raises a self-test flag, which a read then clears.

Top module: `snic_top`

## Requirements
- R1: Only address bits [5:0] are decoded, so offset 0x48 aliases 0x08. The read map is: 0x00 and 0x04 return the identification words ID0 and ID1 (defaults 0x534E4943 and 0x46423031); 0x08 returns busy in bit 0; 0x0C returns the receive count; 0x10 returns the transmit count; 0x14 returns interrupt control; 0x1C is the receive data port. Offset 0x18, offset 0x20 and all unmapped offsets read 0.
- R2: Interrupt control holds transmit done in bit 0, receive done in bit 1 and self-test in bit 31. All other bits read 0. `irq_o` is high exactly when any of these three bits is set.
- R3: Each buffer holds at most MAX_BYTES (default 1514) bytes. A longer received frame is truncated, so the receive count saturates at 1514.
- R4: After reset, busy reads 1 and interrupt control reads 0. The receive count and transmit count both read 0, and `irq_o` is low.
- R5: A frame is accepted only if, at its first beat, busy is 0 and the receive count is below MAX_BYTES. A frame that is not accepted leaves all state unchanged. After the last beat of an accepted frame:
  - busy is 1,
  - the receive count equals the frame length,
  - the read pointer is back at byte 0,
  - receive done is set.
- R6: A read of 0x1C while the receive count is nonzero returns the next frame byte in arrival order and decrements the count. With a count of 0 it returns 0 and changes nothing.
- R7: A read of interrupt control returns its value and then clears the self-test bit. Busy is left unchanged.
- R8: A write to interrupt control is applied by priority:
  - if data bit 0 is set, only transmit done is cleared;
  - otherwise, if bit 1 is set, only receive done is cleared;
  - otherwise, if bit 31 is set, the self-test action of R9 runs.

  After the write, busy equals 1 if any interrupt-control bit remains set, and 0 otherwise.
- R9: The self-test action clears both counts, both pointers, any frame in progress and interrupt control. It then sets the self-test bit, and busy reads 1.
- R10: A write to 0x10 loads the transmit count if the value is at most MAX_BYTES, and loads 0 otherwise. The write also restarts the transmit write pointer at 0.
- R11: Each accepted write to 0x20 stores data bits [7:0] and advances the pointer. The write that brings the pointer to the count queues the frame for sending and clears the count. It also sets transmit done and sets busy to 1.
- R12: Writes to 0x20 are ignored while the transmit count is 0 or while a previous frame is still streaming out.
- R13: A queued frame leaves on `tx_valid_o`/`tx_data_o` in write order, with `tx_last_o` on its final byte. Each byte is held stable until `tx_ready_i` is high at a clock edge.
- R14: Writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Register access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte address; only [5:0] decoded |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Receive byte ends the frame |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Transmit byte ends the frame |
| tx_ready_i | input | 1 | Sink accepts the transmit byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume three things about the inputs. There is at most one register access per cycle, and it is never a read and a write at once. A self-test write never coincides with a transmit byte that is waiting on ready. The receive stream never starts a frame in the same cycle that the processor writes interrupt control.

The stimulus stays inside these limits. Bus accesses are issued one per cycle from tasks. Receive frames are sent only while the bus is idle. The self-test write is issued only after the transmit stream has drained. Ready follows a fixed stalling pattern, so hold cycles occur on every transmitted frame.

// File: rtl/snic_pkg.sv
package snic_pkg;

  typedef enum logic [3:0] {
    SEL_ID0, SEL_ID1, SEL_BUSY, SEL_RXCNT, SEL_TXCNT,
    SEL_ICTL, SEL_INFO, SEL_RXDAT, SEL_TXDAT, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [5:0] off);
    case (off)
      6'h00:   return SEL_ID0;
      6'h04:   return SEL_ID1;
      6'h08:   return SEL_BUSY;
      6'h0C:   return SEL_RXCNT;
      6'h10:   return SEL_TXCNT;
      6'h14:   return SEL_ICTL;
      6'h18:   return SEL_INFO;
      6'h1C:   return SEL_RXDAT;
      6'h20:   return SEL_TXDAT;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/snic_rx.sv
module snic_rx #(
  parameter int MAX_BYTES = 1514,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          busy_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  input  logic          pop_i,
  output logic [CW-1:0] count_o,
  output logic [7:0]    data_o,
  output logic          done_o
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_BYTES);

  logic [7:0]    mem [MAX_BYTES];
  logic          in_frame_q, take_q;
  logic [CW-1:0] wptr_q, rptr_q, cnt_q;
  logic          active, store, done;
  logic [CW-1:0] len;

  always_comb begin
    // acceptance is decided on the first beat and held for the frame
    active = in_frame_q ? take_q : (!busy_i && (cnt_q < MAX_C));
    store  = rx_valid_i && active && (wptr_q < MAX_C);
    done   = rx_valid_i && rx_last_i && active && !clr_i;
    len    = store ? wptr_q + CW'(1) : wptr_q;
  end

  always_ff @(posedge clk_i) begin
    if (store) mem[wptr_q] <= rx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      take_q     <= 1'b0;
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
    end else if (clr_i) begin
      in_frame_q <= 1'b0;
      take_q     <= 1'b0;
      wptr_q     <= '0;
      rptr_q     <= '0;
      cnt_q      <= '0;
    end else begin
      if (rx_valid_i) begin
        if (rx_last_i) begin
          in_frame_q <= 1'b0;
          wptr_q     <= '0;
        end else begin
          in_frame_q <= 1'b1;
          take_q     <= active;
          if (store) wptr_q <= wptr_q + CW'(1);
        end
      end
      if (done) begin
        cnt_q  <= len;
        rptr_q <= '0;
      end else if (pop_i && cnt_q != '0) begin
        cnt_q  <= cnt_q - CW'(1);
        rptr_q <= rptr_q + CW'(1);
      end
    end
  end

  assign count_o = cnt_q;
  assign data_o  = (cnt_q != '0) ? mem[rptr_q] : 8'h00;
  assign done_o  = done;

endmodule

// File: rtl/snic_tx.sv
module snic_tx #(
  parameter int MAX_BYTES = 1514,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cnt_we_i,
  input  logic [31:0]   cnt_val_i,
  input  logic          dat_we_i,
  input  logic [7:0]    dat_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] wptr_o,
  output logic          done_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_BYTES);

  logic [7:0]    mem [MAX_BYTES];
  logic [CW-1:0] cnt_q, wptr_q, sptr_q, slen_q;
  logic          send_q;
  logic [CW-1:0] cnt_load;
  logic          wr_ok, finish, s_last;

  always_comb begin
    cnt_load = (cnt_val_i <= 32'(MAX_BYTES)) ? cnt_val_i[CW-1:0] : '0;
    wr_ok    = dat_we_i && !send_q && (cnt_q != '0) && (wptr_q < MAX_C);
    finish   = wr_ok && ((wptr_q + CW'(1)) == cnt_q);
    s_last   = (sptr_q == slen_q - CW'(1));
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wptr_q] <= dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      sptr_q <= '0;
      slen_q <= '0;
      send_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      wptr_q <= '0;
      sptr_q <= '0;
      slen_q <= '0;
      send_q <= 1'b0;
    end else begin
      if (send_q && tx_ready_i) begin
        if (s_last) send_q <= 1'b0;
        else        sptr_q <= sptr_q + CW'(1);
      end
      if (cnt_we_i) begin
        cnt_q  <= cnt_load;
        wptr_q <= '0;
      end else if (finish) begin
        cnt_q  <= '0;
        wptr_q <= '0;
        send_q <= 1'b1;
        slen_q <= cnt_q;
        sptr_q <= '0;
      end else if (wr_ok) begin
        wptr_q <= wptr_q + CW'(1);
      end
    end
  end

  assign count_o    = cnt_q;
  assign wptr_o     = wptr_q;
  assign done_o     = finish && !clr_i;
  assign tx_valid_o = send_q;
  assign tx_data_o  = mem[sptr_q];
  assign tx_last_o  = send_q && s_last;

endmodule

// File: rtl/snic_top.sv
module snic_top #(
  parameter int          MAX_BYTES = 1514,
  parameter int          AW        = 8,
  parameter logic [31:0] ID0       = 32'h534E_4943,
  parameter logic [31:0] ID1       = 32'h4642_3031
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i,
  output logic          irq_o
);
  import snic_pkg::*;

  localparam int CW = $clog2(MAX_BYTES + 1);

  reg_sel_e      sel;
  logic          rd, wr, ic_rd, ic_wr, soft_clr;
  logic          ic_tx_q, ic_rx_q, ic_st_q, busy_q;
  logic          tx_w, rx_w, st_w, busy_n;
  logic          rx_done, tx_done;
  logic [CW-1:0] rx_cnt, tx_cnt, tx_wptr;
  logic [7:0]    rx_byte;
  logic          unused_addr_hi;

  assign unused_addr_hi = ^bus_addr_i;
  assign sel   = decode_off(bus_addr_i[5:0]);
  assign rd    = bus_req_i && !bus_we_i;
  assign wr    = bus_req_i && bus_we_i;
  assign ic_rd = rd && (sel == SEL_ICTL);
  assign ic_wr = wr && (sel == SEL_ICTL);

  always_comb begin
    tx_w     = ic_tx_q;
    rx_w     = ic_rx_q;
    st_w     = ic_st_q;
    soft_clr = 1'b0;
    if (ic_rd) st_w = 1'b0;
    if (ic_wr) begin
      if (bus_wdata_i[0])       tx_w = 1'b0;
      else if (bus_wdata_i[1])  rx_w = 1'b0;
      else if (bus_wdata_i[31]) begin
        tx_w     = 1'b0;
        rx_w     = 1'b0;
        st_w     = 1'b1;
        soft_clr = 1'b1;
      end
    end
    busy_n = ic_wr ? (tx_w | rx_w | st_w) : busy_q;
    if (tx_done || rx_done) busy_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ic_tx_q <= 1'b0;
      ic_rx_q <= 1'b0;
      ic_st_q <= 1'b0;
      busy_q  <= 1'b1;
    end else begin
      ic_tx_q <= tx_w | tx_done;
      ic_rx_q <= rx_w | rx_done;
      ic_st_q <= st_w;
      busy_q  <= busy_n;
    end
  end

  snic_rx #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_clr),
    .busy_i     (busy_q),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_last_i  (rx_last_i),
    .pop_i      (rd && (sel == SEL_RXDAT)),
    .count_o    (rx_cnt),
    .data_o     (rx_byte),
    .done_o     (rx_done)
  );

  snic_tx #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (soft_clr),
    .cnt_we_i   (wr && (sel == SEL_TXCNT)),
    .cnt_val_i  (bus_wdata_i),
    .dat_we_i   (wr && (sel == SEL_TXDAT)),
    .dat_i      (bus_wdata_i[7:0]),
    .count_o    (tx_cnt),
    .wptr_o     (tx_wptr),
    .done_o     (tx_done),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o),
    .tx_ready_i (tx_ready_i)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_ID0:   bus_rdata_o = ID0;
        SEL_ID1:   bus_rdata_o = ID1;
        SEL_BUSY:  bus_rdata_o = {31'b0, busy_q};
        SEL_RXCNT: bus_rdata_o = 32'(rx_cnt);
        SEL_TXCNT: bus_rdata_o = 32'(tx_cnt);
        SEL_ICTL:  bus_rdata_o = {ic_st_q, 29'b0, ic_rx_q, ic_tx_q};
        SEL_RXDAT: bus_rdata_o = {24'b0, rx_byte};
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = ic_tx_q | ic_rx_q | ic_st_q;

endmodule

// File: rtl/snic_chk.sv
module snic_chk #(
  parameter int MAX_BYTES = 1514,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_i,
  input logic          busy_i,
  input logic          ic_rd_i,
  input logic          ic_st_i,
  input logic          ic_rx_i,
  input logic          rx_done_i,
  input logic          soft_clr_i,
  input logic [CW-1:0] rx_cnt_i,
  input logic [CW-1:0] tx_cnt_i,
  input logic [CW-1:0] tx_wptr_i,
  input logic          tx_valid_i,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_i,
  input logic          tx_last_i
);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_BYTES);

  // R8: a pending interrupt always holds off reception
  p_irq_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> busy_i);

  // R7
  p_st_read_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ic_rd_i |=> !ic_st_i);

  // R3
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_i <= MAX_C);

  // R11
  p_tx_ptr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wptr_i < tx_cnt_i) || (tx_wptr_i == '0));

  // R5
  p_accept_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> (busy_i && ic_rx_i));

  // R13
  p_tx_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_ready_i && !soft_clr_i) |=>
      (tx_valid_i && $stable(tx_data_i) && $stable(tx_last_i)));

endmodule

bind snic_top snic_chk #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_o),
  .busy_i     (busy_q),
  .ic_rd_i    (ic_rd),
  .ic_st_i    (ic_st_q),
  .ic_rx_i    (ic_rx_q),
  .rx_done_i  (rx_done),
  .soft_clr_i (soft_clr),
  .rx_cnt_i   (rx_cnt),
  .tx_cnt_i   (tx_cnt),
  .tx_wptr_i  (tx_wptr),
  .tx_valid_i (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_i  (tx_data_o),
  .tx_last_i  (tx_last_o)
);

// File: tb/snic_top_tb.sv
`timescale 1ns/100ps
module snic_top_tb;
  localparam int MAX = 1514;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  always #2.5 clk = ~clk;

  snic_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference model state
  int          m_busy = 1;
  logic [31:0] m_ic = '0;
  logic [7:0]  rxq[$];
  int          m_txcnt = 0, m_txw = 0;
  logic [7:0]  txbuf[$];
  logic [7:0]  exp_d[$];
  bit          exp_l[$];
  int          got_n = 0;
  logic [31:0] last_rd;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // every clock: interrupt level vs model
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) check(irq == (m_ic != 0), "R2 irq", 32'(irq), 32'(m_ic != 0));
  end

  // transmit sink with fixed stall pattern
  int rdy_cnt = 0;
  always @(negedge clk) begin
    rdy_cnt++;
    tx_ready <= (rdy_cnt % 3) != 1;
  end

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (got_n < exp_d.size()) begin
        check(tx_data == exp_d[got_n], "R13 tx data", 32'(tx_data), 32'(exp_d[got_n]));
        check(tx_last == exp_l[got_n], "R13 tx last", 32'(tx_last), 32'(exp_l[got_n]));
      end else begin
        check(0, "R12 unexpected tx byte", 32'(tx_data), 32'h0);
      end
      got_n++;
    end
  end

  function automatic logic [31:0] m_peek(logic [5:0] off);
    case (off)
      6'h00: return 32'h534E_4943;
      6'h04: return 32'h4642_3031;
      6'h08: return 32'(m_busy);
      6'h0C: return 32'(rxq.size());
      6'h10: return 32'(m_txcnt);
      6'h14: return m_ic;
      6'h1C: return (rxq.size() != 0) ? 32'(rxq[0]) : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_softreset();
    rxq.delete(); txbuf.delete();
    m_txcnt = 0; m_txw = 0;
    while (exp_d.size() > got_n) begin void'(exp_d.pop_back()); void'(exp_l.pop_back()); end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    bit snd;
    @(negedge clk);
    snd = got_n < exp_d.size();
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
    case (a[5:0])
      6'h10: begin
        m_txcnt = (d <= MAX) ? int'(d) : 0; m_txw = 0; txbuf.delete();
      end
      6'h14: begin
        if (d[0]) m_ic[0] = 0;
        else if (d[1]) m_ic[1] = 0;
        else if (d[31]) begin m_softreset(); m_ic = 32'h8000_0000; end
        m_busy = (m_ic != 0);
      end
      6'h20: if (!snd && m_txcnt != 0 && m_txw < MAX) begin
        txbuf.push_back(d[7:0]); m_txw++;
        if (m_txw == m_txcnt) begin
          foreach (txbuf[i]) begin exp_d.push_back(txbuf[i]); exp_l.push_back(i == txbuf.size()-1); end
          txbuf.delete(); m_txcnt = 0; m_txw = 0; m_ic[0] = 1; m_busy = 1;
        end
      end
      default: ;
    endcase
  endtask

  task automatic bus_rd(logic [7:0] a, string tag);
    logic [31:0] e;
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1;
    e = m_peek(a[5:0]);
    last_rd = rdata;
    check(rdata == e, tag, rdata, e);
    @(posedge clk); #1;
    req = 0;
    if (a[5:0] == 6'h14) m_ic[31] = 0;
    if (a[5:0] == 6'h1C && rxq.size() != 0) void'(rxq.pop_front());
  endtask

  task automatic rx_frame(int len, int seed);
    bit take = 0;
    logic [7:0] fr[$];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) take = (m_busy == 0) && (rxq.size() < MAX);
      rx_valid = 1; rx_data = 8'(seed + i * 7); rx_last = (i == len - 1);
      fr.push_back(rx_data);
    end
    @(posedge clk); #1;
    rx_valid = 0; rx_last = 0;
    if (take) begin
      rxq.delete();
      for (int i = 0; i < len && i < MAX; i++) rxq.push_back(fr[i]);
      m_busy = 1; m_ic[1] = 1;
    end
  endtask

  task automatic drain();
    while (got_n < exp_d.size()) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 32'h0, 32'h1);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R4 reset state
    check(irq == 0, "R4 irq", 32'(irq), 0);
    bus_rd(8'h08, "R4 busy"); check(last_rd == 1, "R4 busy literal", last_rd, 1);
    bus_rd(8'h0C, "R4 rxcnt"); bus_rd(8'h10, "R4 txcnt");
    bus_rd(8'h14, "R4 ictl"); check(last_rd == 0, "R4 ictl literal", last_rd, 0);
    // R1 map, aliasing, zero reads
    bus_rd(8'h00, "R1 id0"); check(last_rd == 32'h534E_4943, "R1 id0 literal", last_rd, 32'h534E_4943);
    bus_rd(8'h04, "R1 id1");
    bus_rd(8'h18, "R1 info"); bus_rd(8'h20, "R1 txport"); bus_rd(8'h24, "R1 unmapped");
    bus_rd(8'h48, "R1 alias"); check(last_rd == 1, "R1 alias literal", last_rd, 1);
    // R5 frame ignored while busy
    rx_frame(6, 3);
    bus_rd(8'h0C, "R5 rejected busy"); check(last_rd == 0, "R5 rejected literal", last_rd, 0);
    // R8 write 0 -> busy 0
    bus_wr(8'h14, 32'h0);
    bus_rd(8'h08, "R8 busy clear"); check(last_rd == 0, "R8 busy literal", last_rd, 0);
    // R14 read-only writes
    bus_wr(8'h0C, 32'd5); bus_wr(8'h08, 32'd1); bus_wr(8'h1C, 32'h55); bus_wr(8'h00, 32'h1);
    bus_rd(8'h0C, "R14 rxcnt"); bus_rd(8'h08, "R14 busy"); bus_rd(8'h00, "R14 id0");
    // R5 accept, R6 read out
    rx_frame(5, 8'h40);
    bus_rd(8'h14, "R5 ictl"); check(last_rd == 2, "R5 ictl literal", last_rd, 2);
    bus_rd(8'h08, "R5 busy"); bus_rd(8'h0C, "R5 rxcnt"); check(last_rd == 5, "R5 len", last_rd, 5);
    for (int i = 0; i < 5; i++) bus_rd(8'h1C, "R6 rx byte");
    bus_rd(8'h1C, "R6 empty"); check(last_rd == 0, "R6 empty literal", last_rd, 0);
    bus_rd(8'h0C, "R6 count");
    rx_frame(3, 9);
    bus_rd(8'h0C, "R5 second rejected");
    // R10 / R3 oversize count, R12 count-zero write
    bus_wr(8'h10, 32'd2000);
    bus_rd(8'h10, "R10 oversize"); check(last_rd == 0, "R3 oversize literal", last_rd, 0);
    bus_wr(8'h20, 32'h11);
    bus_rd(8'h10, "R12 count zero");
    // R10 reload, R11 frame completion
    bus_wr(8'h10, 32'd4); bus_rd(8'h10, "R10 load");
    bus_wr(8'h20, 32'hA1);
    bus_wr(8'h10, 32'd3);
    bus_wr(8'h20, 32'hB1); bus_wr(8'h20, 32'hB2); bus_wr(8'h20, 32'hB3);
    bus_rd(8'h14, "R11 ictl"); check(last_rd == 3, "R11 ictl literal", last_rd, 3);
    bus_rd(8'h10, "R11 count cleared");
    // R12 write during streaming
    bus_wr(8'h10, 32'd2); bus_wr(8'h20, 32'hC1);
    drain();
    bus_wr(8'h10, 32'd2); bus_wr(8'h20, 32'hD1); bus_wr(8'h20, 32'hD2);
    drain();
    // R8 priority
    bus_wr(8'h14, 32'h3);
    bus_rd(8'h14, "R8 prio"); check(last_rd == 2, "R8 prio literal", last_rd, 2);
    bus_rd(8'h08, "R8 busy held");
    bus_wr(8'h14, 32'h2);
    bus_rd(8'h08, "R8 busy drop"); check(last_rd == 0, "R8 busy drop literal", last_rd, 0);
    // R3 truncation
    rx_frame(1520, 1);
    bus_rd(8'h0C, "R3 saturate"); check(last_rd == MAX, "R3 saturate literal", last_rd, MAX);
    for (int i = 0; i < 3; i++) bus_rd(8'h1C, "R6 big byte");
    // R9 self-test, R7 read clear
    bus_wr(8'h14, 32'h8000_0000);
    bus_rd(8'h14, "R9 st set"); check(last_rd == 32'h8000_0000, "R9 st literal", last_rd, 32'h8000_0000);
    bus_rd(8'h14, "R7 st cleared"); check(last_rd == 0, "R7 st literal", last_rd, 0);
    bus_rd(8'h08, "R7 busy kept"); bus_rd(8'h0C, "R9 rxcnt");
    // exact maximum frame and a longer transmit
    bus_wr(8'h14, 32'h0);
    rx_frame(MAX, 5);
    bus_rd(8'h0C, "R3 exact max");
    bus_wr(8'h10, 32'd20);
    for (int i = 0; i < 20; i++) bus_wr(8'h20, 32'(8'h60 + i));
    drain();
    bus_rd(8'h14, "R11 final ictl");
    check(got_n == exp_d.size(), "R13 all bytes sent", 32'(got_n), 32'(exp_d.size()));
    repeat (4) @(posedge clk);
    finished = 1;
    summary();
    $finish;
  end

endmodule